// File: doc/BRIEF.md
# Word FIFO with Occupancy Flags

This block is a first-in first-out store for 16-bit words, 256 entries deep. It runs on one system clock. A producer offers words on a parallel write port with a single-cycle write enable. A serializer downstream sees the oldest stored word together with a valid indication, and pulses a take enable when it consumes that word. The read and write paths work independently and may both act in the same cycle.

The block tracks a write pointer, a read pointer and an occupancy count. From the count it decodes four active-low status flags. Empty is low when nothing is stored. Full is low when all entries are in use. Half is low when more than half the depth is occupied. Edge is low when the occupancy is in the lowest or highest eighth of the range. A write while full and a take while empty are both blocked, so the store never overflows or underflows.

Top module: `pser_word_fifo`

## Requirements
- R1: After reset both pointers are at entry zero. empty_n and edge_n are 0, full_n and half_n are 1, and rd_valid is 0.
- R2: Words come out on rd_data in the order they were accepted. rd_valid is 1 whenever at least one word is stored. Each accepted take advances to the next stored word.
- R3: A write enable while the occupancy is 256 (full_n = 0) is ignored. No stored word changes and the count stays at 256.
- R4: A take enable while the occupancy is 0 (empty_n = 0) is ignored. The count stays at 0, and a word written later is the next word presented.
- R5: empty_n is 0 exactly when the occupancy is 0.
- R6: full_n is 0 exactly when the occupancy is 256.
- R7: half_n is 0 exactly when the occupancy is between 129 and 256.
- R8: edge_n is 0 when the occupancy is 0 to 31 or 225 to 256, and 1 when it is 32 to 224.
- R9: When a write and a take are both accepted in one cycle, the occupancy and all four flags keep their values, and the take still returns the oldest word.
- R10: At full, a simultaneous write and take removes one word and drops the write (count becomes 255). At empty, a simultaneous write and take stores the word and drops the take (count becomes 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write enable |
| wr_data | input | 16 | Word to store |
| rd_take | input | 1 | Serializer consumes the presented word |
| rd_data | output | 16 | Oldest stored word |
| rd_valid | output | 1 | A word is presented on rd_data |
| empty_n | output | 1 | Low when occupancy is 0 |
| full_n | output | 1 | Low when occupancy is 256 |
| half_n | output | 1 | Low when occupancy exceeds 128 |
| edge_n | output | 1 | Low in the lowest or highest eighth of occupancy |

## Verification
The ordering test writes a short run of distinct patterns and reads them back. A dropped, repeated or reordered word therefore shows up as a data mismatch. A complete fill to 256 and a complete drain back to 0 compare all four flags at every occupancy, which pins each threshold to its exact count from both directions. Extra writes at full and extra takes at empty show whether blocking is correct, because the data read afterwards and the count reached must both be right. Simultaneous write-and-take cycles are driven in the middle of the range and at both ends, which separates the normal hold behaviour from the two cases where only one side may proceed.

// File: rtl/pser_fifo_pkg.sv
package pser_fifo_pkg;

  // occupancy strictly above half of the depth
  function automatic logic above_half(input int unsigned occ, input int unsigned depth);
    return (occ > (depth / 2));
  endfunction

  // occupancy in the bottom eighth (below depth/8) or top eighth (above 7*depth/8)
  function automatic logic in_edge_band(input int unsigned occ, input int unsigned depth);
    return (occ < (depth / 8)) || (occ > (depth - depth / 8));
  endfunction

endpackage

// File: rtl/pser_fifo_store.sv
module pser_fifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pser_fifo_ctrl.sv
module pser_fifo_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_take,
  output logic          wr_accept,
  output logic          rd_accept,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          word_ready
);
  localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic is_full, is_empty;
  assign is_full  = (occ == OCC_FULL);
  assign is_empty = (occ == '0);

  assign wr_accept  = wr_en && !is_full;
  assign rd_accept  = rd_take && !is_empty;
  assign word_ready = !is_empty;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_accept) wr_ptr <= step(wr_ptr);
      if (rd_accept) rd_ptr <= step(rd_ptr);
      case ({wr_accept, rd_accept})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_FULL && wr_en) |=> $stable(wr_ptr));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && rd_take) |=> $stable(rd_ptr));

  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && rd_accept) |=> $stable(occ));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_FULL);
endmodule

// File: rtl/pser_fifo_flags.sv
module pser_fifo_flags
  import pser_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          edge_n
);
  int unsigned occ_u;
  assign occ_u = 32'(occ);

  assign empty_n = (occ_u != 0);
  assign full_n  = (occ_u != DEPTH);
  assign half_n  = !above_half(occ_u, DEPTH);
  assign edge_n  = !in_edge_band(occ_u, DEPTH);

  // R6
  full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!half_n && !edge_n && empty_n));

  // R5
  empty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (full_n && half_n && !edge_n));
endmodule

// File: rtl/pser_word_fifo.sv
module pser_word_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_take,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             edge_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_accept, rd_accept;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;

  pser_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_take(rd_take),
    .wr_accept(wr_accept), .rd_accept(rd_accept),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .word_ready(rd_valid)
  );

  pser_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_accept), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(rd_data)
  );

  pser_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .occ(occ),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n), .edge_n(edge_n)
  );

  // R2
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == empty_n);
endmodule

// File: tb/pser_word_fifo_bench.sv
`timescale 1ns/1ps
module pser_word_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_take = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid, empty_n, full_n, half_n, edge_n;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  int m_head = 0;
  int m_tail = 0;
  logic [15:0] m_q [256];

  always #4 clk = ~clk;

  pser_word_fifo u_pser_word_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_take(rd_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .edge_n(edge_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (occupancy %0d)", tag, act, exp, m_cnt);
    end
  endtask

  // expected flags from the model count, written as fractions of 256
  task automatic chk_flags(input string tag);
    chk({tag, " R5 empty_n"}, {31'd0, empty_n}, (m_cnt == 0) ? 0 : 1);
    chk({tag, " R6 full_n"},  {31'd0, full_n},  (m_cnt == 256) ? 0 : 1);
    chk({tag, " R7 half_n"},  {31'd0, half_n},  (2 * m_cnt > 256) ? 0 : 1);
    chk({tag, " R8 edge_n"},  {31'd0, edge_n},
        (8 * m_cnt < 256 || 8 * m_cnt > 7 * 256) ? 0 : 1);
    chk({tag, " R2 rd_valid"}, {31'd0, rd_valid}, (m_cnt > 0) ? 1 : 0);
  endtask

  // one clock of stimulus; checks the presented word before the edge and flags after it
  task automatic step(input logic w, input logic [15:0] d, input logic r, input string tag);
    bit w_ok, r_ok;
    @(negedge clk);
    if (r && m_cnt > 0) chk({tag, " R2 rd_data"}, {16'd0, rd_data}, {16'd0, m_q[m_head]});
    wr_en = w; wr_data = d; rd_take = r;
    w_ok = w && (m_cnt < 256);
    r_ok = r && (m_cnt > 0);
    @(negedge clk);
    wr_en = 1'b0; rd_take = 1'b0;
    if (w_ok) begin m_q[m_tail] = d; m_tail = (m_tail + 1) % 256; end
    if (r_ok) m_head = (m_head + 1) % 256;
    m_cnt = m_cnt + (w_ok ? 1 : 0) - (r_ok ? 1 : 0);
    chk_flags(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_head = 0; m_tail = 0;
    @(negedge clk);
    chk("R1 empty_n", {31'd0, empty_n}, 0);
    chk("R1 full_n",  {31'd0, full_n},  1);
    chk("R1 half_n",  {31'd0, half_n},  1);
    chk("R1 edge_n",  {31'd0, edge_n},  0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 0);
  endtask

  task automatic t_order;
    logic [15:0] pat [5] = '{16'h0001, 16'h8000, 16'hA5A5, 16'h5A5A, 16'hFFFF};
    foreach (pat[i]) step(1'b1, pat[i], 1'b0, "R2 order-wr");
    chk("R2 head word", {16'd0, rd_data}, {16'd0, 16'h0001});
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1, "R2 order-rd");
  endtask

  task automatic t_fill_drain;
    for (int i = 0; i < 256; i++) step(1'b1, 16'(i * 16'h0101 + 3), 1'b0, "R7 fill");
    chk("R6 full reached", {31'd0, full_n}, 0);
    step(1'b1, 16'hDEAD, 1'b0, "R3 extra write");
    step(1'b1, 16'hBEEF, 1'b0, "R3 extra write");
    chk("R3 head untouched", {16'd0, rd_data}, {16'd0, m_q[m_head]});
    for (int i = 0; i < 256; i++) step(1'b0, '0, 1'b1, "R8 drain");
    chk("R5 empty reached", {31'd0, empty_n}, 0);
  endtask

  task automatic t_underflow;
    step(1'b0, '0, 1'b1, "R4 take empty");
    step(1'b0, '0, 1'b1, "R4 take empty");
    step(1'b1, 16'h1234, 1'b0, "R4 write after");
    chk("R4 next word", {16'd0, rd_data}, {16'd0, 16'h1234});
    chk("R4 one stored", {31'd0, rd_valid}, 1);
    step(1'b0, '0, 1'b1, "R4 take back");
  endtask

  task automatic t_simul;
    logic e0, f0, h0, a0;
    for (int i = 0; i < 40; i++) step(1'b1, 16'(16'h7000 + i), 1'b0, "R9 prefill");
    e0 = empty_n; f0 = full_n; h0 = half_n; a0 = edge_n;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 16'(16'hC000 + i), 1'b1, "R9 both");
      chk("R9 flags hold", {28'd0, empty_n, full_n, half_n, edge_n},
          {28'd0, e0, f0, h0, a0});
    end
    for (int i = 0; i < 40; i++) step(1'b0, '0, 1'b1, "R9 drain");
  endtask

  task automatic t_ends;
    step(1'b1, 16'h4242, 1'b1, "R10 both at empty");
    chk("R10 empty both word", {16'd0, rd_data}, {16'd0, 16'h4242});
    chk("R10 empty both valid", {31'd0, rd_valid}, 1);
    for (int i = 1; i < 256; i++) step(1'b1, 16'(i), 1'b0, "R10 fill");
    chk("R10 full before", {31'd0, full_n}, 0);
    step(1'b1, 16'h9999, 1'b1, "R10 both at full");
    chk("R10 full after", {31'd0, full_n}, 1);
    chk("R10 head after", {16'd0, rd_data}, {16'd0, 16'h0001});
    while (m_cnt > 0) step(1'b0, '0, 1'b1, "R10 drain");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_fill_drain();
    t_underflow();
    t_simul();
    t_ends();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule